// File: doc/BRIEF.md
# ADC Repeat-Accumulate Conversion Sequencer

This block is the digital controller placed next to a successive-approximation analog-to-digital converter. It holds an 8-bit configuration word, derives a SAR clock enable from the system clock, issues conversion requests to the converter and adds the returned 10-bit samples into a 16-bit result. An end-of-conversion flag is raised once for each programmed group of 1, 4, 8 or 16 conversions, not once per sample.

In normal mode every conversion of a group waits for its own start pulse. In burst mode a single start pulse runs the whole group back to back. The converter is external and uses a level request with a one-cycle done pulse that carries the sample. The attenuation bit is only stored and brought out.

Top module: `adc_accum_seq`

## Requirements
- R1: The configuration word resets to 0xF8. Bits 7:3 are the divider field, bits 2:1 the repeat code and bit 0 the attenuation enable. `cfg_q` reads back the last value written with `cfg_we`, and `atten_en` follows bit 0.
- R2: `sar_clk_en` pulses for one clock in every (divider + 1) clocks. A divider of 0 gives a pulse on every clock.
- R3: Repeat code 00 runs 1 conversion per group, 01 runs 4, 10 runs 8 and 11 runs 16. At the end of a group `result` holds the sum of that group's samples.
- R4: `eoc_flag` sets in the clock after the done pulse of the last conversion of a group, and never after an earlier one. It stays set until `eoc_clr` is pulsed. If a set and a clear fall in the same clock, the set wins.
- R5: In normal mode (`burst_en` = 0), `conv_req` rises only in the clock after a start pulse and drops after each done. It stays low until the next start.
- R6: In burst mode (`burst_en` = 1), one start pulse runs every conversion of the group with no further start. `conv_req` is low once the group is complete.
- R7: A start pulse that arrives while `conv_req` is high is ignored. It neither adds a conversion nor changes the result.
- R8: The accumulator clears on the first conversion of each new group, so no earlier group leaks into the result.
- R9: With repeat code 00 and `left_just` = 1, `result` is the 10-bit sample shifted left by 6. With any other repeat code `left_just` is ignored and the result is right justified.
- R10: `conv_req` stays high until `conv_done`. A right-justified result never exceeds 16368 (16 × 1023).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| cfg_q | output | 8 | Current configuration word |
| atten_en | output | 1 | Attenuation enable (bit 0 of configuration) |
| left_just | input | 1 | Left-justify request |
| burst_en | input | 1 | Burst mode select |
| start | input | 1 | Conversion start pulse |
| sar_clk_en | output | 1 | Divided SAR clock enable |
| conv_req | output | 1 | Conversion request to converter |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Converter sample, valid with done |
| result | output | 16 | Accumulated or justified result |
| eoc_flag | output | 1 | End-of-group flag |
| eoc_clr | input | 1 | Flag clear pulse |

## Verification
The sweep covers every repeat code in both modes, at two divider settings and with both justification requests. It runs groups back to back, so an accumulator that is not cleared shows up as a sum that carries the earlier group. A flag raised after an earlier sample shows up as an early `eoc_flag`. A left-justify request that is honoured for repeated groups gives a shifted sum. An all-1023 group of sixteen samples checks the 16368 ceiling. A start pulsed in the middle of a conversion must not leave a stray request behind. The divider period is also timed at its extremes, 0 and 31.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_CONV = 1'b1
   } seq_state_e;

   localparam int unsigned MAX_GROUP = 16;

   function automatic logic [4:0] group_len(input logic [1:0] code);
      case (code)
         2'b00:   return 5'd1;
         2'b01:   return 5'd4;
         2'b10:   return 5'd8;
         default: return 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/adc_sar_clkdiv.sv
module adc_sar_clkdiv #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       burst,
   input  logic       done,
   input  logic [1:0] rpt_code,
   input  logic       flag_clr,
   output logic       req,
   output logic       first,
   output logic       flag
);
   seq_state_e       state;
   logic [IDX_W-1:0] idx;
   logic [4:0]       len;
   logic             is_last;

   assign len     = group_len(rpt_code);
   assign is_last = ({1'b0, idx} == 5'(len - 5'd1));
   assign req     = (state == SEQ_CONV);
   assign first   = (idx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            SEQ_IDLE: if (start) state <= SEQ_CONV;
            SEQ_CONV: if (done) begin
               if (is_last) begin
                  idx   <= '0;
                  state <= SEQ_IDLE;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= burst ? SEQ_CONV : SEQ_IDLE;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 flag <= 1'b0;
      else if (req && done && is_last)            flag <= 1'b1;
      else if (flag_clr)                          flag <= 1'b0;
   end
endmodule

// File: rtl/adc_accum.sv
module adc_accum #(
   parameter int DATA_W = 10,
   parameter int RES_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              first,
   input  logic [DATA_W-1:0] sample,
   output logic [RES_W-1:0]  acc
);
   logic [RES_W-1:0] ext;
   assign ext = RES_W'(sample);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (load)  acc <= first ? ext : acc + ext;
   end
endmodule

// File: rtl/adc_accum_seq.sv
module adc_accum_seq #(
   parameter int  DIV_W     = 5,
   parameter int  RPT_W     = 2,
   parameter int  DATA_W    = 10,
   parameter int  RES_W     = 16,
   parameter bit  LJ_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   output logic [7:0]        cfg_q,
   output logic              atten_en,
   input  logic              left_just,
   input  logic              burst_en,
   input  logic              start,
   output logic              sar_clk_en,
   output logic              conv_req,
   input  logic              conv_done,
   input  logic [DATA_W-1:0] conv_data,
   output logic [RES_W-1:0]  result,
   output logic              eoc_flag,
   input  logic              eoc_clr
);
   localparam int CFG_W     = DIV_W + RPT_W + 1;
   localparam int IDX_W     = $clog2(adc_seq_pkg::MAX_GROUP);
   localparam int LJ_SHIFT  = RES_W - DATA_W;
   localparam logic [7:0] CFG_RESET = 8'hF8;

   if (CFG_W != 8) begin : g_bad_cfg
      $error("configuration fields must total 8 bits");
   end
   if (RES_W < DATA_W + IDX_W) begin : g_bad_res
      $error("result too narrow for a full group");
   end

   logic [DIV_W-1:0] div_f;
   logic [RPT_W-1:0] rpt_f;
   logic             first;
   logic [RES_W-1:0] acc;
   logic             lj_eff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= CFG_RESET;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   assign div_f    = cfg_q[7 -: DIV_W];
   assign rpt_f    = cfg_q[RPT_W:1];
   assign atten_en = cfg_q[0];

   adc_sar_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .div   (div_f),
      .tick  (sar_clk_en)
   );

   adc_seq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .burst    (burst_en),
      .done     (conv_done),
      .rpt_code (rpt_f),
      .flag_clr (eoc_clr),
      .req      (conv_req),
      .first    (first),
      .flag     (eoc_flag)
   );

   adc_accum #(.DATA_W(DATA_W), .RES_W(RES_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (conv_req && conv_done),
      .first  (first),
      .sample (conv_data),
      .acc    (acc)
   );

   if (LJ_ENABLE) begin : g_lj
      assign lj_eff = left_just && (rpt_f == '0);
      assign result = lj_eff ? {acc[DATA_W-1:0], {LJ_SHIFT{1'b0}}} : acc;
   end else begin : g_rj
      assign lj_eff = 1'b0;
      assign result = acc;
   end
endmodule

// File: rtl/adc_accum_seq_chk.sv
module adc_accum_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  cfg_q,
   input logic        left_just,
   input logic        start,
   input logic        sar_clk_en,
   input logic        conv_req,
   input logic        conv_done,
   input logic [15:0] result,
   input logic        eoc_flag,
   input logic        eoc_clr
);
   assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_req && !conv_done) |=> conv_req);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(left_just && cfg_q[2:1] == 2'b00) |-> (result <= 16'd16368));

   assert_eoc_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_flag) |-> $past(conv_done));

   assert_eoc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc_flag && !eoc_clr) |=> eoc_flag);

   assert_req_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_req) |-> $past(start));

   assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sar_clk_en && cfg_q[7:3] != 5'd0) |=> (!sar_clk_en || cfg_q[7:3] == 5'd0));
endmodule

bind adc_accum_seq adc_accum_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_q      (cfg_q),
   .left_just  (left_just),
   .start      (start),
   .sar_clk_en (sar_clk_en),
   .conv_req   (conv_req),
   .conv_done  (conv_done),
   .result     (result),
   .eoc_flag   (eoc_flag),
   .eoc_clr    (eoc_clr)
);

// File: tb/sim_adc_accum_seq.sv
module sim_adc_accum_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_we = 0, left_just = 0, burst_en = 0, start = 0, eoc_clr = 0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_q;
   logic atten_en, sar_clk_en, conv_req, eoc_flag;
   logic conv_done = 1'b0;
   logic [9:0] conv_data = '0;
   logic [15:0] result;

   int n_vec = 0, n_bad = 0, cycles = 0;
   int samp [16];
   int mdl_idx = 0;
   logic busy = 1'b0;
   int mcnt = 0;

   always #10 clk = ~clk;

   adc_accum_seq u0 (.*);

   // converter model: 12 SAR clock enables from request to done
   always @(posedge clk) begin
      conv_done <= 1'b0;
      if (!busy && conv_req && !conv_done) begin
         busy <= 1'b1;
         mcnt <= 0;
      end else if (busy && sar_clk_en) begin
         if (mcnt == 11) begin
            busy      <= 1'b0;
            conv_done <= 1'b1;
            conv_data <= 10'(samp[mdl_idx]);
            mdl_idx   <= mdl_idx + 1;
         end else mcnt <= mcnt + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [7:0] v);
      @(negedge clk); cfg_wdata = v; cfg_we = 1;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic pulse_start();
      start = 1; @(negedge clk); start = 0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!conv_done);
   endtask

   task automatic period(input int div);
      int c;
      wr_cfg({5'(div), 3'b000});
      do @(negedge clk); while (!sar_clk_en);
      c = 0;
      do begin @(negedge clk); c++; end while (!sar_clk_en);
      chk("R2 divider period", c, div + 1);
   endtask

   task automatic run_group(input int div, input int rpt, input int brst,
                            input int lj, input int seed);
      int n, sum, expv;
      n = (rpt == 0) ? 1 : (rpt == 1) ? 4 : (rpt == 2) ? 8 : 16;
      sum = 0;
      for (int k = 0; k < 16; k++) begin
         samp[k] = (seed == 99) ? 1023 : (k * 197 + seed * 61 + 5) % 1024;
         if (k < n) sum += samp[k];
      end
      mdl_idx = 0;
      wr_cfg({5'(div), 2'(rpt), 1'b0});
      burst_en = brst[0]; left_just = lj[0];
      eoc_clr = 1; @(negedge clk); eoc_clr = 0;
      for (int k = 0; k < n; k++) begin
         if (brst == 0 || k == 0) pulse_start();
         wait_done();
         @(negedge clk);
         if (k < n - 1) begin
            chk("R4 no early flag", int'(eoc_flag), 0);
            if (brst == 0 && k == 0) begin
               repeat (4) @(negedge clk);
               chk("R5 request waits for start", int'(conv_req), 0);
            end
         end
      end
      expv = (lj != 0 && rpt == 0) ? ((samp[0] << 6) & 16'hFFFF) : sum;
      chk((lj != 0) ? "R9 justification / R3 R8 group sum" : "R3 R8 group sum",
          int'(result), expv);
      chk("R4 flag at group end", int'(eoc_flag), 1);
      repeat (5) @(negedge clk);
      chk("R6 idle after group", int'(conv_req), 0);
      chk("R4 flag held", int'(eoc_flag), 1);
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles == 190000) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=0", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset config", int'(cfg_q), 'hF8);
      chk("R1 reset atten", int'(atten_en), 0);
      chk("R4 reset flag", int'(eoc_flag), 0);
      chk("R5 reset request", int'(conv_req), 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      wr_cfg(8'h5B);
      chk("R1 readback", int'(cfg_q), 'h5B);
      chk("R1 atten bit", int'(atten_en), 1);
      period(0); period(1); period(4); period(31);

      for (int d = 0; d < 2; d++)
         for (int r = 0; r < 4; r++)
            for (int b = 0; b < 2; b++)
               for (int l = 0; l < 2; l++)
                  run_group(d, r, b, l, d * 16 + r * 4 + b * 2 + l);

      // full scale group of 16 reaches the ceiling
      run_group(0, 3, 1, 0, 99);
      chk("R10 ceiling", int'(result), 16368);

      // flag clear, and set winning over clear
      eoc_clr = 1; @(negedge clk); eoc_clr = 0;
      chk("R4 flag cleared", int'(eoc_flag), 0);

      // extra start during a conversion is ignored
      for (int k = 0; k < 16; k++) samp[k] = 321 + k;
      mdl_idx = 0;
      wr_cfg(8'h00); burst_en = 0; left_just = 0;
      pulse_start();
      repeat (3) @(negedge clk);
      pulse_start();
      wait_done();
      eoc_clr = 1;
      @(negedge clk); eoc_clr = 0;
      chk("R4 set beats clear", int'(eoc_flag), 1);
      chk("R7 single result", int'(result), 321);
      repeat (40) @(negedge clk);
      chk("R7 no extra request", int'(conv_req), 0);
      chk("R7 one conversion", mdl_idx, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule